// File: doc/BRIEF.md
# Dual-Write Register File with Deferred Second Write

A register file offering three read ports and two write ports per request, built from storage banks that each accept only one write per clock. Each read port is served by its own copy of the storage, and every storage write is applied to all copies at once, so the three reads never compete for a bank.

When a request carries two writes to different registers, the first write (port A) goes into storage at the clock edge. The second (port B) is parked in a one-entry holding buffer and moves into storage on the following edge. That following cycle is given over to the drain. The block raises a registered `stall` for exactly that cycle, and any write request presented while `stall` is high is dropped. The requester keeps it on the inputs until `stall` falls. Reads are never blocked. Each read port first looks at writes accepted in the current cycle, then at the holding buffer, and only then at storage, so a read never returns a stale value.

Top module: `dwrf_top`

## Requirements
- R1: The three read ports are independent and combinational. `rdN_data` follows `rdN_addr` in the same cycle, and all three ports may address any register at once.
- R2: A single accepted write on either port updates the named register at the clock edge. From the next cycle on, every read port returns the new value.
- R3: An accepted request with both `wa_en` and `wb_en` set and differing addresses stores port A's data at the first edge and port B's data at the second edge. After that, both values are readable on every port.
- R4: `stall` is high in exactly the one cycle after an accepted dual write to differing addresses, and low in every other cycle. It is never high in two consecutive cycles.
- R5: While `stall` is high, `wa_en` and `wb_en` are ignored. No register changes because of them, and their data is not forwarded to any read port.
- R6: During the drain cycle, a read whose address equals the buffered register returns the buffered data.
- R7: If both writes of one request name the same register, only port B's data is kept, and no stall follows.
- R8: A synchronous active-high `rst` clears `stall` and the holding buffer, so `stall` is low in the cycle after reset. Storage contents keep their values across reset.
- R9: Read priority, from highest to lowest: an accepted port-B write to that address in the same cycle, then an accepted port-A write, then the holding buffer, then storage.
- R10: Data width (`DW`, default 32) and register count (`NREGS`, default 32) are parameters checked at elaboration. The address width is derived from `NREGS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wa_en | input | 1 | Write port A request |
| wa_addr | input | AW | Write port A register index |
| wa_data | input | DW | Write port A data |
| wb_en | input | 1 | Write port B request |
| wb_addr | input | AW | Write port B register index |
| wb_data | input | DW | Write port B data |
| rd0_addr | input | AW | Read port 0 register index |
| rd0_data | output | DW | Read port 0 data |
| rd1_addr | input | AW | Read port 1 register index |
| rd1_data | output | DW | Read port 1 data |
| rd2_addr | input | AW | Read port 2 register index |
| rd2_data | output | DW | Read port 2 data |
| stall | output | 1 | High for the drain cycle; writes are ignored while high |

## Verification
The two functions that can fall in the same cycle are the drain of the holding buffer into storage and a fresh write request arriving from the requester. The bench provokes this by issuing a dual write and then keeping new write requests on the inputs during the stall cycle, including a second dual write. It judges the result from the read ports. During the stall, the buffered register must read the buffered value and the ignored writes must not be forwarded. Afterwards, the held requests must land only once `stall` has fallen, and the registers they named must show no trace of the dropped attempt.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;

   // Source of the single storage write performed in a cycle
   typedef enum logic [1:0] {
      WSRC_NONE = 2'd0,
      WSRC_A    = 2'd1,
      WSRC_B    = 2'd2,
      WSRC_HOLD = 2'd3
   } wsrc_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dwrf_wctl.sv
module dwrf_wctl
   import dwrf_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   output logic          st_we,
   output logic [AW-1:0] st_addr,
   output logic [DW-1:0] st_data,
   output logic          a_go,
   output logic          b_go,
   output logic          hold_v,
   output logic [AW-1:0] hold_addr,
   output logic [DW-1:0] hold_data
);

   logic  take;
   logic  split;
   wsrc_e src;

   // Requests are taken only while no drain is pending
   assign take  = !hold_v;
   assign a_go  = take && wa_en;
   assign b_go  = take && wb_en;
   assign split = a_go && b_go && (wa_addr != wb_addr);

   always_comb begin
      if (hold_v)      src = WSRC_HOLD;
      else if (split)  src = WSRC_A;
      else if (b_go)   src = WSRC_B;
      else if (a_go)   src = WSRC_A;
      else             src = WSRC_NONE;
   end

   always_comb begin
      st_we   = (src != WSRC_NONE);
      st_addr = '0;
      st_data = '0;
      unique case (src)
         WSRC_A:    begin st_addr = wa_addr;   st_data = wa_data;   end
         WSRC_B:    begin st_addr = wb_addr;   st_data = wb_data;   end
         WSRC_HOLD: begin st_addr = hold_addr; st_data = hold_data; end
         default:   ;
      endcase
   end

   // Holding buffer; its valid flag doubles as the registered stall
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_v <= 1'b0;
      end else begin
         hold_v <= split;
      end
   end

   always_ff @(posedge clk) begin
      if (split) begin
         hold_addr <= wb_addr;
         hold_data <= wb_data;
      end
   end

   p_stall_once_r4: assert property (@(posedge clk) disable iff (rst)
      hold_v |=> !hold_v);

   p_split_stalls_r4: assert property (@(posedge clk) disable iff (rst)
      (!hold_v && wa_en && wb_en && (wa_addr != wb_addr)) |=> hold_v);

   p_same_addr_nostall_r7: assert property (@(posedge clk) disable iff (rst)
      (!hold_v && wa_en && wb_en && (wa_addr == wb_addr)) |=> !hold_v);

   p_drain_only_r5: assert property (@(posedge clk) disable iff (rst)
      hold_v |-> (st_we && (st_addr == hold_addr) && !a_go && !b_go));

   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> !hold_v);

endmodule

// File: rtl/dwrf_bank.sv
module dwrf_bank #(
   parameter int unsigned DW    = 32,
   parameter int unsigned NREGS = 32,
   parameter int unsigned AW    = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam bit FULL = ((1 << AW) == NREGS);

   logic [DW-1:0] mem [NREGS];

   generate
      if (FULL) begin : g_full
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
         assign rdata = mem[raddr];
      end else begin : g_part
         logic w_ok;
         logic r_ok;
         assign w_ok = ({1'b0, waddr} < (AW+1)'(NREGS));
         assign r_ok = ({1'b0, raddr} < (AW+1)'(NREGS));
         always_ff @(posedge clk) begin
            if (we && w_ok) mem[waddr] <= wdata;
         end
         assign rdata = r_ok ? mem[raddr] : '0;
      end
   endgenerate

   p_bank_store_r2: assert property (@(posedge clk)
      (we && ({1'b0, waddr} < (AW+1)'(NREGS))) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dwrf_fwd.sv
module dwrf_fwd #(
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 5,
   parameter bit          SAME_CY = 1'b1
) (
   input  logic [AW-1:0] raddr,
   input  logic [DW-1:0] st_rdata,
   input  logic          b_go,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_data,
   input  logic          a_go,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_data,
   input  logic          hold_v,
   input  logic [AW-1:0] hold_addr,
   input  logic [DW-1:0] hold_data,
   output logic [DW-1:0] rdata
);

   logic          hold_hit;
   logic [DW-1:0] late;

   assign hold_hit = hold_v && (hold_addr == raddr);
   assign late     = hold_hit ? hold_data : st_rdata;

   generate
      if (SAME_CY) begin : g_bypass
         logic b_hit;
         logic a_hit;
         assign b_hit = b_go && (b_addr == raddr);
         assign a_hit = a_go && (a_addr == raddr);
         always_comb begin
            if (b_hit)      rdata = b_data;
            else if (a_hit) rdata = a_data;
            else            rdata = late;
         end
      end else begin : g_nobypass
         logic unused_ok;
         assign unused_ok = ^{b_go, b_addr, b_data, a_go, a_addr, a_data};
         assign rdata = late;
      end
   endgenerate

endmodule

// File: rtl/dwrf_top.sv
module dwrf_top
   import dwrf_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned NREGS = 32,
   parameter int unsigned AW    = idx_width(NREGS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   input  logic [AW-1:0] rd0_addr,
   output logic [DW-1:0] rd0_data,
   input  logic [AW-1:0] rd1_addr,
   output logic [DW-1:0] rd1_data,
   input  logic [AW-1:0] rd2_addr,
   output logic [DW-1:0] rd2_data,
   output logic          stall
);

   localparam int unsigned NRD = 3;

   initial begin
      a_dw_r10: assert (DW > 0) else $error("DW must be positive");
      a_nregs_r10: assert (NREGS >= 2) else $error("NREGS must be at least 2");
      a_aw_r10: assert ((1 << AW) >= NREGS) else $error("AW too narrow for NREGS");
   end

   logic          st_we;
   logic [AW-1:0] st_addr;
   logic [DW-1:0] st_data;
   logic          a_go;
   logic          b_go;
   logic          hold_v;
   logic [AW-1:0] hold_addr;
   logic [DW-1:0] hold_data;

   logic [AW-1:0] raddr_v [NRD];
   logic [DW-1:0] rdata_v [NRD];

   assign raddr_v[0] = rd0_addr;
   assign raddr_v[1] = rd1_addr;
   assign raddr_v[2] = rd2_addr;
   assign rd0_data   = rdata_v[0];
   assign rd1_data   = rdata_v[1];
   assign rd2_data   = rdata_v[2];
   assign stall      = hold_v;

   dwrf_wctl #(.DW(DW), .AW(AW)) u_wctl (
      .clk       (clk),
      .rst       (rst),
      .wa_en     (wa_en),
      .wa_addr   (wa_addr),
      .wa_data   (wa_data),
      .wb_en     (wb_en),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data),
      .st_we     (st_we),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .a_go      (a_go),
      .b_go      (b_go),
      .hold_v    (hold_v),
      .hold_addr (hold_addr),
      .hold_data (hold_data)
   );

   // One storage copy per read port, all written together
   generate
      for (genvar k = 0; k < NRD; k++) begin : g_port
         logic [DW-1:0] st_rdata;

         dwrf_bank #(.DW(DW), .NREGS(NREGS), .AW(AW)) u_bank (
            .clk   (clk),
            .we    (st_we),
            .waddr (st_addr),
            .wdata (st_data),
            .raddr (raddr_v[k]),
            .rdata (st_rdata)
         );

         dwrf_fwd #(.DW(DW), .AW(AW), .SAME_CY(1'b1)) u_fwd (
            .raddr     (raddr_v[k]),
            .st_rdata  (st_rdata),
            .b_go      (b_go),
            .b_addr    (wb_addr),
            .b_data    (wb_data),
            .a_go      (a_go),
            .a_addr    (wa_addr),
            .a_data    (wa_data),
            .hold_v    (hold_v),
            .hold_addr (hold_addr),
            .hold_data (hold_data),
            .rdata     (rdata_v[k])
         );
      end
   endgenerate

   p_hold_read_r6: assert property (@(posedge clk) disable iff (rst)
      (stall && (rd0_addr == $past(wb_addr))) |-> (rd0_data == $past(wb_data)));

   p_stall_cause_r4: assert property (@(posedge clk) disable iff (rst)
      (!stall && !(wa_en && wb_en)) |=> !stall);

endmodule

// File: tb/sim_dwrf_top.sv
module sim_dwrf_top;

   localparam int CLK_P = 10;
   localparam int DW    = 32;
   localparam int NREGS = 32;
   localparam int AW    = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic          wa_en, wb_en;
   logic [AW-1:0] wa_addr, wb_addr;
   logic [DW-1:0] wa_data, wb_data;
   logic [AW-1:0] rd0_addr, rd1_addr, rd2_addr;
   logic [DW-1:0] rd0_data, rd1_data, rd2_data;
   logic          stall;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dwrf_top #(.DW(DW), .NREGS(NREGS)) u0 (
      .clk(clk), .rst(rst),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_addr(rd1_addr), .rd1_data(rd1_data),
      .rd2_addr(rd2_addr), .rd2_data(rd2_data),
      .stall(stall)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      wa_en = 1'b0; wb_en = 1'b0;
   endtask

   task automatic wr_a(input int a, input logic [DW-1:0] d);
      wa_en = 1'b1; wa_addr = AW'(a); wa_data = d;
   endtask

   task automatic wr_b(input int a, input logic [DW-1:0] d);
      wb_en = 1'b1; wb_addr = AW'(a); wb_data = d;
   endtask

   task automatic rd(input int a0, input int a1, input int a2);
      rd0_addr = AW'(a0); rd1_addr = AW'(a1); rd2_addr = AW'(a2);
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1; idle(); rd(0, 0, 0);
      tick(); tick();
      rst = 1'b0;
      chk("R8 stall low after reset", DW'(stall), 0);
   endtask

   task automatic t_single();
      idle(); wr_a(3, 32'h1111_0003); tick();
      idle(); wr_b(7, 32'h2222_0007); tick();
      idle(); rd(3, 7, 3);
      chk("R2 port A write", rd0_data, 32'h1111_0003);
      chk("R2 port B write", rd1_data, 32'h2222_0007);
      chk("R1 third port same reg", rd2_data, 32'h1111_0003);
      rd(7, 3, 7);
      chk("R1 port0 swap", rd0_data, 32'h2222_0007);
      chk("R1 port2 swap", rd2_data, 32'h2222_0007);
      chk("R2 no stall on single write", DW'(stall), 0);
   endtask

   task automatic t_same_cycle();
      idle(); wr_a(9, 32'h0000_AAAA); rd(9, 3, 9);
      chk("R9 same-cycle A bypass", rd0_data, 32'h0000_AAAA);
      chk("R9 other port from storage", rd1_data, 32'h1111_0003);
      tick(); idle();
   endtask

   task automatic t_dual();
      idle(); wr_a(4, 32'h0000_0044); wr_b(5, 32'h0000_0055); rd(4, 5, 6);
      chk("R9 dual A bypass", rd0_data, 32'h44);
      chk("R9 dual B bypass", rd1_data, 32'h55);
      tick(); idle();
      chk("R4 stall after dual", DW'(stall), 1);
      rd(5, 4, 5);
      chk("R6 buffered read port0", rd0_data, 32'h55);
      chk("R3 A value in storage", rd1_data, 32'h44);
      chk("R6 buffered read port2", rd2_data, 32'h55);
      tick();
      chk("R4 stall one cycle only", DW'(stall), 0);
      rd(5, 4, 4);
      chk("R3 B value drained", rd0_data, 32'h55);
      chk("R3 A value kept", rd1_data, 32'h44);
   endtask

   task automatic t_ignore();
      idle(); wr_a(12, 32'h0000_00C0); wr_b(15, 32'h0000_0015); tick();
      chk("R4 stall after setup dual", DW'(stall), 1);
      tick(); idle();
      wr_a(13, 32'h0000_000D); wr_b(14, 32'h0000_000E); tick();
      chk("R4 stall before ignore", DW'(stall), 1);
      wr_a(12, 32'hBAD0_0012); wr_b(15, 32'hBAD0_0015); rd(12, 15, 14);
      chk("R5 no bypass of ignored A", rd0_data, 32'hC0);
      chk("R5 no bypass of ignored B", rd1_data, 32'h15);
      chk("R6 buffer during ignore", rd2_data, 32'h0E);
      tick(); idle();
      chk("R5 stall dropped", DW'(stall), 0);
      rd(12, 15, 13);
      chk("R5 ignored A had no effect", rd0_data, 32'hC0);
      chk("R5 ignored B had no effect", rd1_data, 32'h15);
      chk("R3 A of dual kept", rd2_data, 32'h0D);
   endtask

   task automatic t_same_addr();
      idle(); wr_a(20, 32'h0000_0A20); wr_b(20, 32'h0000_0B20); rd(20, 20, 20);
      chk("R9 B over A same cycle", rd0_data, 32'hB20);
      tick(); idle();
      chk("R7 no stall on same addr", DW'(stall), 0);
      rd(20, 0, 0);
      chk("R7 B data kept", rd0_data, 32'hB20);
   endtask

   task automatic t_back_to_back();
      idle(); wr_a(21, 32'h21); wr_b(22, 32'h22); tick();
      chk("R4 first dual stalls", DW'(stall), 1);
      wr_a(23, 32'h23); wr_b(24, 32'h24); tick();
      chk("R4 held dual accepted after stall", DW'(stall), 0);
      tick(); idle();
      chk("R4 second dual stalls", DW'(stall), 1);
      tick();
      rd(21, 22, 23);
      chk("R3 b2b 21", rd0_data, 32'h21);
      chk("R3 b2b 22", rd1_data, 32'h22);
      chk("R3 b2b 23", rd2_data, 32'h23);
      rd(24, 0, 0);
      chk("R3 b2b 24", rd0_data, 32'h24);
   endtask

   task automatic t_reset_keep();
      idle(); wr_a(25, 32'h25); tick();
      wr_a(26, 32'h26); wr_b(27, 32'h27); tick(); idle();
      chk("R4 stall before reset", DW'(stall), 1);
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R8 reset clears stall", DW'(stall), 0);
      rd(25, 26, 4);
      chk("R8 storage kept 25", rd0_data, 32'h25);
      chk("R8 storage kept 26", rd1_data, 32'h26);
      chk("R8 storage kept 4", rd2_data, 32'h44);
   endtask

   initial begin
      wa_addr = '0; wb_addr = '0; wa_data = '0; wb_data = '0;
      t_reset();
      t_single();
      t_same_cycle();
      t_dual();
      t_ignore();
      t_same_addr();
      t_back_to_back();
      t_reset_keep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule